// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is a bank of general-purpose I/O lines. Software reaches it through a small byte-wide register port, where every register type is split into 8-line groups. Each line has the following state:

- an output data bit and an output-enable (direction) bit, both driven straight to the pad;
- a test bit that loops the line's own output data back into its interrupt detector in place of the pin;
- an interrupt enable;
- a level/edge mode selector and an active-polarity selector;
- a sticky pending flag, which is cleared by writing a one to it;
- a lock bit.

Pin inputs are resynchronised through two flops before detection. All enabled pending lines are merged into one interrupt request.

Which lines exist on a given build is set outside the block and arrives as a static availability vector. That vector can be read back, and it stops absent lines from ever raising a pending flag.

A line whose lock and enable bits are both set is frozen. Writes to its direction, enable, mode, polarity and lock bits are dropped. Its output data and test bits stay writable. Its pending flag can still be cleared.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset all output, direction, test, enable, mode, polarity, lock and pending bits are 0. `gpio_oe` and `irq_o` are therefore 0, and every line starts in level mode with active-low polarity.
- R2: With mode bit = 1 (edge), a line's pending bit is set once per transition of its pin into the active level. It becomes visible on the third rising clock edge after the pin changes: two synchroniser stages plus the detector.
- R3: With mode bit = 0 (level), the pending bit is set on every cycle that the synchronised line sits at its active level. A clear written during that time has no lasting effect, and it only holds once the line is inactive.
- R4: Writing 1 to a pending bit (register code 6) clears it, and writing 0 leaves it unchanged. A detection event in the same cycle as a clear leaves the bit set.
- R5: Polarity bit = 1 selects active-high/rising, and 0 selects active-low/falling. A transition in the opposite direction sets nothing.
- R6: While a line's lock bit (code 8) and enable bit (code 3) are both 1, writes to its direction (code 1), enable, mode (code 4), polarity (code 5) and lock bits are ignored. Output data (code 0) and test (code 2) remain writable. Lock without enable freezes nothing.
- R7: Address bits [5:4] select the 8-line group, and bit b of the group is line group*8+b. Bits [3:0] select the register. Bit positions beyond the last line read 0; with 19 lines, group 2 bits 7:3 read 0. Group 3 and codes 10–15 read 0.
- R8: Code 7 reads the availability vector, where 0 means the line is absent. An absent line never sets its pending bit.
- R9: `irq_o` is 1 exactly when some line has both its pending and enable bits at 1.
- R10: `gpio_o` follows the output data bits and `gpio_oe` follows the direction bits. With test = 1 (code 2), the line's detector watches its output data bit one cycle after it is written, instead of the pin.
- R11: Code 9 reads the synchronised pin values, which lag the pins by two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_LINES | Asynchronous pin inputs |
| avail_i | input | NUM_LINES | Static line-present vector |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {group, register code} |
| wr_data | input | 8 | Write data for one group |
| rd_addr | input | 6 | Read address {group, register code} |
| rd_data | output | 8 | Combinational read data |
| gpio_o | output | NUM_LINES | Output data to pads |
| gpio_oe | output | NUM_LINES | Output enables to pads |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can collide in one cycle: a software clear of a pending bit, and a new detection on the same line. The bench times a rising pin so that its detection lands on exactly the clock edge that carries the write-1 clear. It then expects the bit to survive.

The same collision happens continuously in level mode, where a clear is written while the input stays active. A second collision pairs a lock taking effect with the writes that follow it.

A behavioural reference model advances on every clock. It is compared against the read port, the pad outputs and the interrupt on every cycle, including a long pseudo-random stretch in which writes, pin toggles and reads all coincide.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GRP_W    = 8;
    localparam int GRP_BITS = 2;
    localparam int SEL_BITS = 4;
    localparam int ADDR_W   = GRP_BITS + SEL_BITS;
    localparam int MAX_LINES = GRP_W * (1 << GRP_BITS);

    typedef enum logic [SEL_BITS-1:0] {
        RG_OUT   = 4'd0,
        RG_DIR   = 4'd1,
        RG_TEST  = 4'd2,
        RG_IEN   = 4'd3,
        RG_MODE  = 4'd4,
        RG_POL   = 4'd5,
        RG_PEND  = 4'd6,
        RG_AVAIL = 4'd7,
        RG_LOCK  = 4'd8,
        RG_LEVEL = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic                 en;
        logic [GRP_BITS-1:0]  grp;
        logic [SEL_BITS-1:0]  sel;
        logic [GRP_W-1:0]     data;
    } wr_req_t;

    function automatic int grp_of(input int line);
        return line / GRP_W;
    endfunction

    function automatic int bit_of(input int line);
        return line % GRP_W;
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_bank_det.sv
module gpio_bank_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic mode_edge,
    input  logic pol_high,
    input  logic present,
    output logic set_o
);
    logic prev_q;
    logic active;

    assign active = (din == pol_high);
    assign set_o  = present && active && (!mode_edge || (din != prev_q));

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= din;
    end

    AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (rst)
        (mode_edge && set_o) |=> (!(mode_edge && set_o) || (pol_high != $past(pol_high)))); // R2
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wreq,
    input  logic [N-1:0]      set_i,
    input  logic [N-1:0]      avail_i,
    input  logic [N-1:0]      level_i,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [GRP_W-1:0]  rd_data,
    output logic [N-1:0]      out_q,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      test_q,
    output logic [N-1:0]      ien_q,
    output logic [N-1:0]      mode_q,
    output logic [N-1:0]      pol_q,
    output logic [N-1:0]      pend_q
);
    localparam int NGRP = (N + GRP_W - 1) / GRP_W;
    localparam int TOPB = N - (NGRP - 1) * GRP_W;

    logic [N-1:0] lock_q;
    logic [N-1:0] wmask;
    logic [N-1:0] wbits;
    logic [N-1:0] frozen;
    logic [N-1:0] open_mask;
    logic [N-1:0] clr_mask;
    logic [MAX_LINES-1:0] rvec;

    function automatic logic [N-1:0] merge(input logic [N-1:0] old,
                                           input logic [N-1:0] m,
                                           input logic [N-1:0] d);
        return (old & ~m) | (d & m);
    endfunction

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wmask[i] = wreq.en && (grp_of(i) == int'(wreq.grp));
            wbits[i] = wreq.data[bit_of(i)];
        end
    end

    assign frozen    = lock_q & ien_q;
    assign open_mask = wmask & ~frozen;
    assign clr_mask  = (wreq.sel == RG_PEND) ? (wmask & wbits) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            test_q <= '0;
            ien_q  <= '0;
            mode_q <= '0;
            pol_q  <= '0;
            lock_q <= '0;
            pend_q <= '0;
        end else begin
            case (wreq.sel)
                RG_OUT:  out_q  <= merge(out_q,  wmask,     wbits);
                RG_TEST: test_q <= merge(test_q, wmask,     wbits);
                RG_DIR:  dir_q  <= merge(dir_q,  open_mask, wbits);
                RG_IEN:  ien_q  <= merge(ien_q,  open_mask, wbits);
                RG_MODE: mode_q <= merge(mode_q, open_mask, wbits);
                RG_POL:  pol_q  <= merge(pol_q,  open_mask, wbits);
                RG_LOCK: lock_q <= merge(lock_q, open_mask, wbits);
                default: ;
            endcase
            pend_q <= (pend_q & ~clr_mask) | set_i;
        end
    end

    always_comb begin
        case (rd_addr[SEL_BITS-1:0])
            RG_OUT:   rvec = MAX_LINES'(out_q);
            RG_DIR:   rvec = MAX_LINES'(dir_q);
            RG_TEST:  rvec = MAX_LINES'(test_q);
            RG_IEN:   rvec = MAX_LINES'(ien_q);
            RG_MODE:  rvec = MAX_LINES'(mode_q);
            RG_POL:   rvec = MAX_LINES'(pol_q);
            RG_PEND:  rvec = MAX_LINES'(pend_q);
            RG_AVAIL: rvec = MAX_LINES'(avail_i);
            RG_LOCK:  rvec = MAX_LINES'(lock_q);
            RG_LEVEL: rvec = MAX_LINES'(level_i);
            default:  rvec = '0;
        endcase
        rd_data = rvec[rd_addr[ADDR_W-1:SEL_BITS] * GRP_W +: GRP_W];
    end

    AST_LOCK_DIR:  assert property (@(posedge clk) disable iff (rst)
        ((dir_q  ^ $past(dir_q))  & $past(frozen)) == '0); // R6
    AST_LOCK_IEN:  assert property (@(posedge clk) disable iff (rst)
        ((ien_q  ^ $past(ien_q))  & $past(frozen)) == '0); // R6
    AST_LOCK_CFG:  assert property (@(posedge clk) disable iff (rst)
        (((mode_q ^ $past(mode_q)) | (pol_q ^ $past(pol_q)) | (lock_q ^ $past(lock_q)))
         & $past(frozen)) == '0); // R6
    AST_TOP_ZERO:  assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr[ADDR_W-1:SEL_BITS]) == NGRP - 1) |-> ((rd_data >> TOPB) == '0)); // R7
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_LINES = 19
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic [NUM_LINES-1:0] avail_i,
    input  logic                 wr_en,
    input  logic [5:0]           wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [5:0]           rd_addr,
    output logic [7:0]           rd_data,
    output logic [NUM_LINES-1:0] gpio_o,
    output logic [NUM_LINES-1:0] gpio_oe,
    output logic                 irq_o
);
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] det_src;
    logic [NUM_LINES-1:0] set_v;
    logic [NUM_LINES-1:0] out_q, dir_q, test_q, ien_q, mode_q, pol_q, pend_q;
    wr_req_t wreq;

    assign wreq.en   = wr_en;
    assign wreq.grp  = wr_addr[5:4];
    assign wreq.sel  = wr_addr[3:0];
    assign wreq.data = wr_data;

    gpio_bank_sync #(.W(NUM_LINES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .q   (sync_q)
    );

    assign det_src = (test_q & out_q) | (~test_q & sync_q);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        gpio_bank_det u_det (
            .clk       (clk),
            .rst       (rst),
            .din       (det_src[i]),
            .mode_edge (mode_q[i]),
            .pol_high  (pol_q[i]),
            .present   (avail_i[i]),
            .set_o     (set_v[i])
        );
    end

    gpio_bank_regs #(.N(NUM_LINES)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wreq    (wreq),
        .set_i   (set_v),
        .avail_i (avail_i),
        .level_i (sync_q),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .test_q  (test_q),
        .ien_q   (ien_q),
        .mode_q  (mode_q),
        .pol_q   (pol_q),
        .pend_q  (pend_q)
    );

    assign gpio_o  = out_q;
    assign gpio_oe = dir_q;
    assign irq_o   = |(pend_q & ien_q);

    AST_PEND_BY_EVENT: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(set_v)) == '0); // R4
    AST_ABSENT_QUIET:  assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~avail_i) == '0); // R8
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_q != '0)); // R9
    AST_RESET_QUIET:   assert property (@(posedge clk)
        $past(rst) |-> (!irq_o && gpio_oe == '0)); // R1
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
    localparam int N = 19;
    localparam logic [N-1:0] AVAIL = 19'h7DFEF;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] pins;
    logic         wr_en;
    logic [5:0]   wr_addr;
    logic [7:0]   wr_data;
    logic [5:0]   rd_addr;
    logic [7:0]   rd_data;
    logic [N-1:0] gpio_o, gpio_oe;
    logic         irq_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_bank #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst(rst), .pin_i(pins), .avail_i(AVAIL),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .gpio_o(gpio_o), .gpio_oe(gpio_oe), .irq_o(irq_o)
    );

    // behavioural reference model
    logic [31:0] m_out, m_dir, m_test, m_ien, m_mode, m_pol, m_pend, m_lock;
    logic [31:0] m_s1, m_s2, m_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_out = 0; m_dir = 0; m_test = 0; m_ien = 0; m_mode = 0;
            m_pol = 0; m_pend = 0; m_lock = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            logic [31:0] setv, nprev, clr;
            setv = 0; nprev = 0; clr = 0;
            for (int i = 0; i < N; i++) begin
                logic d;
                d = m_test[i] ? m_out[i] : m_s2[i];
                nprev[i] = d;
                if (AVAIL[i] && d == m_pol[i] && (!m_mode[i] || d != m_prev[i]))
                    setv[i] = 1'b1;
            end
            if (wr_en) begin
                for (int b = 0; b < 8; b++) begin
                    int ln;
                    bit fz;
                    ln = int'(wr_addr[5:4]) * 8 + b;
                    if (ln < N) begin
                        fz = m_lock[ln] && m_ien[ln];
                        case (int'(wr_addr[3:0]))
                            0: m_out[ln]  = wr_data[b];
                            2: m_test[ln] = wr_data[b];
                            1: if (!fz) m_dir[ln]  = wr_data[b];
                            3: if (!fz) m_ien[ln]  = wr_data[b];
                            4: if (!fz) m_mode[ln] = wr_data[b];
                            5: if (!fz) m_pol[ln]  = wr_data[b];
                            8: if (!fz) m_lock[ln] = wr_data[b];
                            6: clr[ln] = wr_data[b];
                            default: ;
                        endcase
                    end
                end
            end
            m_pend = (m_pend & ~clr) | setv;
            m_prev = nprev;
            m_s2 = m_s1;
            m_s1 = 32'(pins);
        end
    end

    function automatic logic [7:0] m_read(input logic [5:0] a);
        logic [31:0] v;
        case (int'(a[3:0]))
            0: v = m_out;  1: v = m_dir;  2: v = m_test; 3: v = m_ien;
            4: v = m_mode; 5: v = m_pol;  6: v = m_pend; 7: v = 32'(AVAIL);
            8: v = m_lock; 9: v = m_s2;
            default: v = 0;
        endcase
        return v[int'(a[5:4]) * 8 +: 8];
    endfunction

    function automatic logic [5:0] A(input int g, input int c);
        return 6'((g << 4) | c);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk({tag, " rd_data"}, 32'(rd_data), 32'(m_read(rd_addr)));
        chk({tag, " irq R9"}, 32'(irq_o), 32'(|(m_pend & m_ien)));
        chk({tag, " gpio_o R10"}, 32'(gpio_o), m_out & 32'h7FFFF);
        chk({tag, " gpio_oe R10"}, 32'(gpio_oe), m_dir & 32'h7FFFF);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(tag);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [7:0] e, input string tag);
        rd_addr = a;
        step(tag);
        chk(tag, 32'(rd_data), 32'(e));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        rst = 1'b1; pins = '1; wr_en = 1'b0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        idle(3, "R1");
        rst = 1'b0;
        rd_chk(A(0, 0), 8'h00, "R1 out");
        rd_chk(A(0, 1), 8'h00, "R1 dir");
        rd_chk(A(1, 3), 8'h00, "R1 ien");
        rd_chk(A(2, 4), 8'h00, "R1 mode");
        chk("R1 oe", 32'(gpio_oe), 0);
        chk("R1 irq", 32'(irq_o), 0);
        idle(2, "R1");
        for (int g = 0; g < 3; g++) wr(A(g, 6), 8'hFF, "R4");
        idle(2, "R4");

        // output path and loopback test mode
        wr(A(0, 0), 8'hA5, "R10");
        wr(A(0, 1), 8'h0F, "R10");
        chk("R10 out", 32'(gpio_o[7:0]), 32'hA5);
        chk("R10 oe", 32'(gpio_oe[7:0]), 32'h0F);
        wr(A(1, 4), 8'h01, "R10");
        wr(A(1, 5), 8'h01, "R10");
        wr(A(1, 2), 8'h01, "R10");
        wr(A(1, 6), 8'hFF, "R10");
        idle(2, "R10");
        rd_addr = A(1, 6);
        wr(A(1, 0), 8'h01, "R10");
        chk("R10 loop not yet", 32'(rd_data[0]), 0);
        step("R10");
        chk("R10 loop pend", 32'(rd_data[0]), 1);
        wr(A(1, 2), 8'h00, "R10");
        wr(A(1, 6), 8'hFF, "R10");

        // edge detection and polarity on line 0
        wr(A(0, 4), 8'h01, "R2");
        wr(A(0, 5), 8'h01, "R5");
        wr(A(0, 3), 8'h01, "R2");
        pins[0] = 1'b0;
        idle(4, "R2");
        wr(A(0, 6), 8'hFF, "R2");
        rd_addr = A(0, 6);
        pins[0] = 1'b1;
        step("R2"); chk("R2 edge+1", 32'(rd_data[0]), 0);
        step("R2"); chk("R2 edge+2", 32'(rd_data[0]), 0);
        step("R2"); chk("R2 edge+3", 32'(rd_data[0]), 1);
        chk("R9 irq on", 32'(irq_o), 1);
        wr(A(0, 6), 8'h01, "R2");
        idle(2, "R2");
        chk("R2 once", 32'(rd_data[0]), 0);
        pins[0] = 1'b0;
        idle(4, "R5");
        chk("R5 falling ignored", 32'(rd_data[0]), 0);
        wr(A(0, 5), 8'h00, "R5");
        wr(A(0, 6), 8'hFF, "R5");
        pins[0] = 1'b1;
        idle(4, "R5");
        chk("R5 rising ignored", 32'(rd_data[0]), 0);
        pins[0] = 1'b0;
        idle(4, "R5");
        chk("R5 falling seen", 32'(rd_data[0]), 1);

        // level mode on line 1
        wr(A(0, 3), 8'h03, "R3");
        wr(A(0, 5), 8'h02, "R3");
        idle(3, "R3");
        wr(A(0, 6), 8'h02, "R3");
        chk("R3 clear while active", 32'(rd_data[1]), 1);
        pins[1] = 1'b0;
        idle(4, "R3");
        wr(A(0, 6), 8'h02, "R3");
        idle(1, "R3");
        chk("R3 clear once inactive", 32'(rd_data[1]), 0);

        // clear colliding with an edge on line 2
        wr(A(0, 4), 8'h05, "R4");
        wr(A(0, 5), 8'h06, "R4");
        pins[2] = 1'b0;
        idle(4, "R4");
        wr(A(0, 6), 8'h04, "R4");
        pins[2] = 1'b1;
        step("R4"); step("R4");
        wr(A(0, 6), 8'h04, "R4");
        chk("R4 event beats clear", 32'(rd_data[2]), 1);
        wr(A(0, 6), 8'h00, "R4");
        chk("R4 zero write", 32'(rd_data[2]), 1);

        // lock
        wr(A(0, 3), 8'h23, "R6");
        wr(A(0, 8), 8'h60, "R6");
        wr(A(0, 1), 8'hFF, "R6");
        chk("R6 dir frozen", 32'(gpio_oe[7:0]), 32'hDF);
        wr(A(0, 3), 8'h00, "R6");
        rd_chk(A(0, 3), 8'h20, "R6 ien frozen");
        wr(A(0, 8), 8'h00, "R6");
        rd_chk(A(0, 8), 8'h20, "R6 lock frozen");
        wr(A(0, 0), 8'h20, "R6");
        chk("R6 out writable", 32'(gpio_o[7:0]), 32'h20);
        wr(A(0, 2), 8'h20, "R6");
        rd_chk(A(0, 2), 8'h20, "R6 test writable");
        wr(A(0, 2), 8'h00, "R6");

        // address map and availability
        for (int g = 0; g < 4; g++)
            for (int c = 0; c < 16; c++) begin
                rd_addr = A(g, c);
                step("R7");
            end
        rd_chk(A(2, 7), 8'h07, "R8 avail top");
        rd_chk(A(0, 7), 8'hEF, "R8 avail low");
        rd_chk(A(3, 0), 8'h00, "R7 group3");
        rd_chk(A(0, 12), 8'h00, "R7 unused code");
        wr(A(2, 0), 8'hFF, "R7");
        rd_chk(A(2, 0), 8'h07, "R7 top bits zero");
        wr(A(0, 6), 8'hFF, "R8");
        pins[3] = 1'b0; pins[4] = 1'b0;
        idle(4, "R8");
        rd_chk(A(0, 6), 8'h08, "R8 absent line quiet");
        pins = '1;
        idle(3, "R8");

        // synchronised level readback
        rd_addr = A(1, 9);
        pins[9] = 1'b0;
        step("R11"); chk("R11 lag1", 32'(rd_data[1]), 1);
        step("R11"); chk("R11 lag2", 32'(rd_data[1]), 0);
        pins[9] = 1'b1;
        idle(3, "R11");

        // interrupt masking
        for (int g = 0; g < 3; g++) wr(A(g, 3), 8'h00, "R9");
        for (int g = 0; g < 3; g++) wr(A(g, 6), 8'hFF, "R9");
        idle(2, "R9");
        rd_chk(A(0, 6), 8'h02, "R9 pend present");
        chk("R9 masked", 32'(irq_o), 0);

        // pseudo-random stretch
        lf = 32'h1F2E3D4C;
        for (int k = 0; k < 4000; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if (lf[3:0] == 0) pins[lf[8:4] % N] = ~pins[lf[8:4] % N];
            rd_addr = lf[14:9];
            wr_en   = (lf[17:15] == 0);
            wr_addr = {lf[19:18] % 2'd3, lf[23:20] % 4'd10};
            wr_data = lf[31:24];
            step("R9 random");
        end
        wr_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule